// File: doc/BRIEF.md
# Factory Calibration Trim Calculator

This block turns factory-test data into per-sensor 12-bit trim words for an on-die temperature sensor array. After a start pulse it takes in a stream of 16-bit words. The first word holds the factory ambient temperature in tenths of a degree, plus a 2-bit test-mode flag. Each following word is the raw reading that one sensor gave at that temperature.

For each sensor, the block turns the raw reading into millidegrees with a linear model, `OFFSET - raw*SCALE/10`. It subtracts the factory temperature from that result and scales the difference back into register units with `*10/SCALE`. It then subtracts this value from the midpoint 0x800.

Results that fit in 12 bits are written and flagged valid. Any other result leaves that sensor at the midpoint. Both divisions share one multi-cycle restoring divider, and the block holds busy high until the last sensor is finished.

Top module: `cal_trim_calc`

## Requirements
- R1: After reset every 12-bit trim field reads 0x800, every valid flag is 0, and busy, done, error and the mode flag are all 0.
- R2: Start is accepted only while busy is low, and busy is high in the next cycle. A start pulse while busy has no effect on the result. At the end of a run, done is high for exactly one cycle, in the first cycle with busy low.
- R3: The factory temperature is bits [11:0] of the first word, in 0.1 degree units, and is multiplied by 100 to give millidegrees. Bits [13:12] of the first word appear on mode_flag_o after the run. Bits [15:14] are ignored.
- R4: For sensor i, with raw reading r, temperature T = OFFSET - r*SCALE/10 and trim = 0x800 - ((T - Tfactory)*10/SCALE). Both divisions truncate toward zero in signed arithmetic.
- R5: A trim result outside 0..4095 (any bit set above bit 11) leaves that field at 0x800 with its valid flag 0. An in-range result is written and its valid flag set to 1.
- R6: Sensor i's field sits in output word i/2 (trim_words_o bits [32*(i/2)+31 : 32*(i/2)]), at bits [11:0] for even i and [27:16] for odd i. All other bits of each word are 0.
- R7: If the first word is 0x0000, or the run ends (last flag) before SENSORS+1 words have arrived, the run is rejected. Error goes high, all fields return to 0x800 and all valid flags clear.
- R8: Words after the (SENSORS+1)-th word of a run are ignored, and so are words presented while no run is collecting. While idle, the outputs do not change.
- R9: Error is cleared when a new run is accepted and stays low after a run that is not rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a run (taken while idle) |
| word_valid_i | input | 1 | word_i carries a data word this cycle |
| word_i | input | 16 | Factory data word |
| word_last_i | input | 1 | Marks the final word of the run |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 1 | Last run was rejected |
| mode_flag_o | output | 2 | Test-mode flag from the first word |
| trim_words_o | output | 32*((SENSORS+1)/2) | Packed trim fields, two per 32-bit word |
| trim_valid_o | output | SENSORS | Per-sensor trim written flag |

## Verification
The assertions assume that start is a single-cycle pulse and that the word stream is presented only after a start has been accepted. They also assume the data-path inputs carry no X values after reset. The bench drives every input on the falling edge and pulses start for one cycle, so it keeps within these limits. It still sends stray words while idle and extra start pulses while busy, because the design must ignore both. The random first words keep the factory temperature between 15 and 45 degrees. Most raw readings are drawn near the value that gives a mid-range trim, and a share of them is drawn wide so that results fall out of range in both directions.

// File: rtl/cal_trim_pkg.sv
package cal_trim_pkg;
  localparam int CALC_W = 32;
  localparam int TRIM_W = 12;
  localparam logic [TRIM_W-1:0] TRIM_MID = 12'h800;

  typedef enum logic [2:0] {
    ST_IDLE, ST_COLLECT, ST_DIV_A, ST_WAIT_A, ST_DIV_B, ST_WAIT_B, ST_APPLY
  } cal_state_e;

  // factory reference: tenths of a degree -> millidegrees
  function automatic logic signed [CALC_W-1:0] ft_to_milli(input logic [15:0] w);
    logic signed [CALC_W-1:0] t;
    t = $signed({20'd0, w[11:0]});
    return t * 32'sd100;
  endfunction

  function automatic logic [CALC_W-1:0] scaled_reading(input logic [15:0] raw,
                                                       input logic [CALC_W-1:0] scale);
    return {16'd0, raw} * scale;
  endfunction

  function automatic logic signed [CALC_W-1:0] reading_to_milli(
      input logic [CALC_W-1:0] quot, input logic signed [CALC_W-1:0] offs);
    return offs - $signed(quot);
  endfunction

  // apply the sign removed before the unsigned divide, then offset from midpoint
  function automatic logic signed [CALC_W-1:0] trim_from_quot(input logic [CALC_W-1:0] quot,
                                                              input logic neg);
    logic signed [CALC_W-1:0] sq;
    sq = neg ? -$signed(quot) : $signed(quot);
    return $signed({20'd0, TRIM_MID}) - sq;
  endfunction

  function automatic logic fits_trim(input logic signed [CALC_W-1:0] v);
    return v[CALC_W-1:TRIM_W] == '0;
  endfunction
endpackage

// File: rtl/cal_restoring_div.sv
module cal_restoring_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         done_o,
  output logic [W-1:0] quot_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, quo_q, dsr_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, done_q;
  logic [W:0]    rem_sh, trial;

  assign rem_sh = {rem_q, quo_q[W-1]};
  assign trial  = rem_sh - {1'b0, dsr_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dsr_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      rem_q  <= '0;
      quo_q  <= dividend_i;
      dsr_q  <= divisor_i;
      cnt_q  <= CW'(W);
      run_q  <= 1'b1;
      done_q <= 1'b0;
    end else if (run_q) begin
      if (!trial[W]) begin
        rem_q <= trial[W-1:0];
        quo_q <= {quo_q[W-2:0], 1'b1};
      end else begin
        rem_q <= rem_sh[W-1:0];
        quo_q <= {quo_q[W-2:0], 1'b0};
      end
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign quot_o = quo_q;
endmodule

// File: rtl/cal_word_collector.sv
module cal_word_collector #(
  parameter int SENSORS = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  arm_i,
  input  logic                  word_valid_i,
  input  logic [15:0]           word_i,
  input  logic                  word_last_i,
  output logic                  end_o,
  output logic                  complete_o,
  output logic [15:0]           first_word_o,
  output logic [SENSORS*16-1:0] raw_o
);
  localparam int NEED = SENSORS + 1;
  localparam int CW   = $clog2(NEED + 1);

  logic          coll_q, end_q;
  logic [CW-1:0] cnt_q;
  logic [15:0]   first_q;
  logic [15:0]   raw_q [SENSORS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coll_q  <= 1'b0;
      end_q   <= 1'b0;
      cnt_q   <= '0;
      first_q <= '0;
      for (int i = 0; i < SENSORS; i++) raw_q[i] <= '0;
    end else begin
      end_q <= 1'b0;
      if (arm_i) begin
        coll_q  <= 1'b1;
        cnt_q   <= '0;
        first_q <= '0;
      end else if (coll_q && word_valid_i) begin
        if (cnt_q == '0) first_q <= word_i;
        for (int i = 0; i < SENSORS; i++)
          if (cnt_q == CW'(i + 1)) raw_q[i] <= word_i;
        if (cnt_q < CW'(NEED)) cnt_q <= cnt_q + 1'b1;
        if (word_last_i) begin
          coll_q <= 1'b0;
          end_q  <= 1'b1;
        end
      end
    end
  end

  generate
    for (genvar g = 0; g < SENSORS; g++) begin : g_raw
      assign raw_o[g*16 +: 16] = raw_q[g];
    end
  endgenerate

  assign end_o        = end_q;
  assign complete_o   = (cnt_q == CW'(NEED));
  assign first_word_o = first_q;
endmodule

// File: rtl/cal_trim_bank.sv
module cal_trim_bank
  import cal_trim_pkg::*;
#(
  parameter int SENSORS = 3,
  localparam int IW = (SENSORS > 1) ? $clog2(SENSORS) : 1,
  localparam int OUT_WORDS = (SENSORS + 1) / 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear_i,
  input  logic                   wr_i,
  input  logic [IW-1:0]          wr_idx_i,
  input  logic [TRIM_W-1:0]      wr_data_i,
  input  logic                   wr_ok_i,
  output logic [OUT_WORDS*32-1:0] trim_words_o,
  output logic [SENSORS-1:0]     valid_o
);
  logic [TRIM_W-1:0] field_q [SENSORS];

  generate
    for (genvar g = 0; g < SENSORS; g++) begin : g_field
      always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
          field_q[g] <= TRIM_MID;
          valid_o[g] <= 1'b0;
        end else if (wr_i && wr_idx_i == IW'(g)) begin
          field_q[g] <= wr_ok_i ? wr_data_i : TRIM_MID;
          valid_o[g] <= wr_ok_i;
        end
      end
    end

    for (genvar w = 0; w < OUT_WORDS; w++) begin : g_word
      assign trim_words_o[w*32 +: 16] = {4'd0, field_q[2*w]};
      if (2*w + 1 < SENSORS) begin : g_hi
        assign trim_words_o[w*32+16 +: 16] = {4'd0, field_q[2*w+1]};
      end else begin : g_pad
        assign trim_words_o[w*32+16 +: 16] = '0;
      end
    end
  endgenerate
endmodule

// File: rtl/cal_trim_calc.sv
module cal_trim_calc
  import cal_trim_pkg::*;
#(
  parameter int SENSORS = 3,
  parameter int SCALE   = 672,
  parameter int OFFSET  = 187744,
  localparam int OUT_WORDS = (SENSORS + 1) / 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    word_valid_i,
  input  logic [15:0]             word_i,
  input  logic                    word_last_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    err_o,
  output logic [1:0]              mode_flag_o,
  output logic [OUT_WORDS*32-1:0] trim_words_o,
  output logic [SENSORS-1:0]      trim_valid_o
);
  localparam int IW = (SENSORS > 1) ? $clog2(SENSORS) : 1;
  localparam logic [CALC_W-1:0]        SCALE_V  = CALC_W'(SCALE);
  localparam logic signed [CALC_W-1:0] OFFSET_V = CALC_W'(OFFSET);

  cal_state_e state_q;
  logic [IW-1:0] idx_q;
  logic          done_q, err_q;
  logic [1:0]    mode_q;
  logic          prod_neg_q;
  logic [CALC_W-1:0] prod_mag_q;
  logic signed [CALC_W-1:0] trim_val_q;

  // named events
  logic run_accept, run_reject, collect_end, collect_ok, div_start, div_done, trim_write;
  logic [15:0]           first_word;
  logic [SENSORS*16-1:0] raw_flat;
  logic [CALC_W-1:0]     div_dividend, div_divisor, div_quot;
  logic signed [CALC_W-1:0] temp_milli, diff_milli, prod;

  assign run_accept = (state_q == ST_IDLE) && start_i;
  assign run_reject = (state_q == ST_COLLECT) && collect_end &&
                      ((first_word == 16'h0000) || !collect_ok);
  assign div_start  = (state_q == ST_DIV_A) || (state_q == ST_DIV_B);
  assign trim_write = (state_q == ST_APPLY);

  cal_word_collector #(.SENSORS(SENSORS)) u_coll (
    .clk          (clk),
    .rst_n        (rst_n),
    .arm_i        (run_accept),
    .word_valid_i (word_valid_i),
    .word_i       (word_i),
    .word_last_i  (word_last_i),
    .end_o        (collect_end),
    .complete_o   (collect_ok),
    .first_word_o (first_word),
    .raw_o        (raw_flat)
  );

  assign div_dividend = (state_q == ST_DIV_B) ? prod_mag_q
                                              : scaled_reading(raw_flat[idx_q*16 +: 16], SCALE_V);
  assign div_divisor  = (state_q == ST_DIV_B) ? SCALE_V : CALC_W'(10);

  cal_restoring_div #(.W(CALC_W)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (div_start),
    .dividend_i (div_dividend),
    .divisor_i  (div_divisor),
    .done_o     (div_done),
    .quot_o     (div_quot)
  );

  assign temp_milli = reading_to_milli(div_quot, OFFSET_V);
  assign diff_milli = temp_milli - ft_to_milli(first_word);
  assign prod       = diff_milli * 32'sd10;

  cal_trim_bank #(.SENSORS(SENSORS)) u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear_i      (run_reject),
    .wr_i         (trim_write),
    .wr_idx_i     (idx_q),
    .wr_data_i    (trim_val_q[TRIM_W-1:0]),
    .wr_ok_i      (fits_trim(trim_val_q)),
    .trim_words_o (trim_words_o),
    .valid_o      (trim_valid_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      mode_q     <= 2'b00;
      prod_neg_q <= 1'b0;
      prod_mag_q <= '0;
      trim_val_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          err_q   <= 1'b0;
          state_q <= ST_COLLECT;
        end
        ST_COLLECT: if (collect_end) begin
          mode_q <= first_word[13:12];
          if (run_reject) begin
            err_q   <= 1'b1;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            idx_q   <= '0;
            state_q <= ST_DIV_A;
          end
        end
        ST_DIV_A: state_q <= ST_WAIT_A;
        ST_WAIT_A: if (div_done) begin
          prod_neg_q <= prod[CALC_W-1];
          prod_mag_q <= prod[CALC_W-1] ? CALC_W'(-prod) : CALC_W'(prod);
          state_q    <= ST_DIV_B;
        end
        ST_DIV_B: state_q <= ST_WAIT_B;
        ST_WAIT_B: if (div_done) begin
          trim_val_q <= trim_from_quot(div_quot, prod_neg_q);
          state_q    <= ST_APPLY;
        end
        ST_APPLY: begin
          if (idx_q == IW'(SENSORS - 1)) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_DIV_A;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign mode_flag_o = mode_q;
endmodule

// File: rtl/cal_trim_calc_chk.sv
module cal_trim_calc_chk #(
  parameter int SENSORS = 3,
  localparam int OUT_WORDS = (SENSORS + 1) / 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start_i,
  input logic                    busy_o,
  input logic                    done_o,
  input logic                    err_o,
  input logic [1:0]              mode_flag_o,
  input logic [OUT_WORDS*32-1:0] trim_words_o,
  input logic [SENSORS-1:0]      trim_valid_o,
  input logic                    run_reject
);
  p_busy_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> busy_o);

  p_done_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> $stable(mode_flag_o));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(trim_words_o) && $stable(trim_valid_o) && $stable(err_o)));

  p_reject_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run_reject |=> (err_o && trim_valid_o == '0));

  p_err_no_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (trim_valid_o == '0));

  generate
    for (genvar g = 0; g < SENSORS; g++) begin : g_def
      p_default_field_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !trim_valid_o[g] |-> (trim_words_o[(g/2)*32 + (g%2)*16 +: 12] == 12'h800));
    end
  endgenerate
endmodule

bind cal_trim_calc cal_trim_calc_chk #(.SENSORS(SENSORS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .err_o        (err_o),
  .mode_flag_o  (mode_flag_o),
  .trim_words_o (trim_words_o),
  .trim_valid_o (trim_valid_o),
  .run_reject   (run_reject)
);

// File: tb/cal_trim_calc_tb.sv
module cal_trim_calc_tb;
  localparam int NS = 3;
  localparam int SC = 672;
  localparam int OF = 187744;
  localparam int OW = (NS + 1) / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, word_valid_i = 1'b0, word_last_i = 1'b0;
  logic [15:0] word_i = '0;
  logic busy_o, done_o, err_o;
  logic [1:0] mode_flag_o;
  logic [OW*32-1:0] trim_words_o;
  logic [NS-1:0] trim_valid_o;

  int checks = 0, errors = 0, cyc = 0;
  logic [15:0] stim [8];

  always #4 clk = ~clk;

  cal_trim_calc #(.SENSORS(NS), .SCALE(SC), .OFFSET(OF)) u_dut (.*);

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      errors++;
      $display("FAIL watchdog: actual cycles=%0d expected below 190000", cyc);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  function automatic int ref_trim(input logic [15:0] w0, input logic [15:0] raw);
    int ft, t, d;
    ft = int'(w0[11:0]) * 100;
    t  = OF - (int'(raw) * SC) / 10;
    d  = ((t - ft) * 10) / SC;
    return 2048 - d;
  endfunction

  function automatic int field(input int i);
    return int'(trim_words_o[(i/2)*32 + (i%2)*16 +: 12]);
  endfunction

  // n words from stim; optional noise while busy
  task automatic run(input int n, input bit noise);
    int waitc;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    chk(busy_o === 1'b1, "R2 busy after start", int'(busy_o), 1);
    for (int k = 0; k < n; k++) begin
      word_valid_i = 1'b1; word_i = stim[k]; word_last_i = (k == n - 1);
      @(negedge clk);
    end
    word_valid_i = 1'b0; word_last_i = 1'b0;
    if (noise) begin
      start_i = 1'b1; word_valid_i = 1'b1; word_i = 16'h0FFF; word_last_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0; word_valid_i = 1'b0; word_last_i = 1'b0;
    end
    waitc = 0;
    while (done_o !== 1'b1 && waitc < 5000) begin
      @(negedge clk); waitc++;
    end
    chk(done_o === 1'b1 && busy_o === 1'b0, "R2 done pulse with busy low", int'(done_o), 1);
    @(negedge clk);
    chk(done_o === 1'b0, "R2 done one cycle", int'(done_o), 0);
  endtask

  task automatic expect_run(input int n);
    bit rej;
    int tv;
    rej = (stim[0] == 16'h0000) || (n < NS + 1);
    chk(err_o === rej, rej ? "R7 error on reject" : "R9 error low", int'(err_o), int'(rej));
    if (!rej)
      chk(mode_flag_o === stim[0][13:12], "R3 mode flag", int'(mode_flag_o), int'(stim[0][13:12]));
    for (int i = 0; i < NS; i++) begin
      if (rej) begin
        chk(field(i) == 'h800 && trim_valid_o[i] === 1'b0, "R7 field default", field(i), 'h800);
      end else begin
        tv = ref_trim(stim[0], stim[i+1]);
        if (tv >= 0 && tv <= 4095) begin
          chk(field(i) == tv, "R4 trim value", field(i), tv);
          chk(trim_valid_o[i] === 1'b1, "R5 valid set", int'(trim_valid_o[i]), 1);
        end else begin
          chk(field(i) == 'h800, "R5 out-of-range field", field(i), 'h800);
          chk(trim_valid_o[i] === 1'b0, "R5 valid clear", int'(trim_valid_o[i]), 0);
        end
      end
    end
    for (int w = 0; w < OW; w++) begin
      chk(trim_words_o[w*32+12 +: 4] == 4'd0 && trim_words_o[w*32+28 +: 4] == 4'd0,
          "R6 pad bits zero", int'(trim_words_o[w*32 +: 32]), 0);
    end
    if (NS % 2 == 1)
      chk(trim_words_o[(OW-1)*32+16 +: 16] == 16'd0, "R6 unused upper half",
          int'(trim_words_o[(OW-1)*32+16 +: 16]), 0);
  endtask

  function automatic logic [15:0] center_raw(input int ft10);
    return 16'((OF - ft10 * 100) * 10 / SC);
  endfunction

  initial begin
    logic [15:0] snap_w;
    int ft10;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int i = 0; i < NS; i++) chk(field(i) == 'h800, "R1 reset field", field(i), 'h800);
    chk(trim_valid_o == '0, "R1 reset valid", int'(trim_valid_o), 0);
    chk(!busy_o && !done_o && !err_o && mode_flag_o == 2'b00, "R1 reset control",
        int'({busy_o, done_o, err_o, mode_flag_o}), 0);

    // R8 words while idle are ignored
    word_valid_i = 1'b1; word_i = 16'h1234; word_last_i = 1'b1;
    repeat (3) @(negedge clk);
    word_valid_i = 1'b0; word_last_i = 1'b0;
    @(negedge clk);
    chk(!busy_o && trim_valid_o == '0 && field(0) == 'h800, "R8 idle words ignored", field(0), 'h800);

    // directed: mode flag, bits 15:14 set, exact data
    stim[0] = 16'hE000 | 16'd250;
    stim[1] = center_raw(250); stim[2] = center_raw(250) + 16'd300; stim[3] = center_raw(250) - 16'd500;
    run(NS + 1, 1'b0); expect_run(NS + 1);

    // out of range both directions (R5)
    stim[0] = 16'h1000 | 16'd300;
    stim[1] = 16'd0; stim[2] = 16'd60000; stim[3] = center_raw(300);
    run(NS + 1, 1'b0); expect_run(NS + 1);

    // too few words (R7), after a run that left a valid flag
    stim[0] = 16'd250; stim[1] = 16'd2400; stim[2] = 16'd2400;
    run(NS, 1'b0); expect_run(NS);

    // first word zero (R7)
    stim[0] = 16'h0000; stim[1] = 16'd2400; stim[2] = 16'd2400; stim[3] = 16'd2400;
    run(NS + 1, 1'b0); expect_run(NS + 1);

    // extra words plus start/words while busy are ignored (R8, R2)
    stim[0] = 16'h2000 | 16'd400;
    stim[1] = center_raw(400) + 16'd50; stim[2] = center_raw(400) - 16'd50; stim[3] = center_raw(400);
    stim[4] = 16'd0; stim[5] = 16'd65535;
    run(NS + 3, 1'b1); expect_run(NS + 1);
    snap_w = trim_words_o[15:0];
    repeat (5) @(negedge clk);
    chk(trim_words_o[15:0] == snap_w && !busy_o, "R8 outputs hold while idle",
        int'(trim_words_o[15:0]), int'(snap_w));

    // random runs
    for (int r = 0; r < 40; r++) begin
      ft10 = 150 + int'($urandom_range(300));
      stim[0] = {2'($urandom_range(3)), 2'($urandom_range(3)), 12'(ft10)};
      for (int s = 1; s <= NS; s++) begin
        if ($urandom_range(3) == 0) stim[s] = 16'($urandom_range(65535));
        else stim[s] = center_raw(ft10) + 16'($urandom_range(3000)) - 16'd1500;
      end
      run(NS + 1, 1'($urandom_range(1))); expect_run(NS + 1);
    end
    finish_run();
  end
endmodule